// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Controller

This block controls 85 general-purpose pins split into three banks of up to 32 pins. Banks 0 and 1 have 32 pins each and bank 2 has 21. Each pin has a direction bit and an output latch. The latch is driven through separate write-one set and write-one clear strobes. Software can read back the synchronized pin level, whatever the pin's direction.

Every pin can also record edges. It has its own rising-edge enable and falling-edge enable. An enabled edge sets a sticky status bit, and software clears that bit by writing a one to it. Three interrupt lines leave the block: pin 0 and pin 1 each own a dedicated line, and every other pin shares the third.

Software reaches the block through a plain synchronous port. It presents a word address and either a write strobe with data, or nothing for a read. Read data appears one clock later.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every direction bit, output latch, edge enable and status bit is 0, so pin_oe, pin_out and all three interrupt lines are low.
- R2: A direction bit of 1 makes the pin an output (pin_oe high) and 0 makes it an input; the direction register reads back what was written.
- R3: In bank 2 only bits 0..20 exist: the other bits of every bank 2 register read 0 and ignore writes.
- R4: Writing the set register drives the output latch high for each 1 bit; writing the clear register drives it low for each 1 bit; 0 bits leave the latch unchanged. Reading either address returns the latch.
- R5: A latch value loaded while the pin is an input appears on pin_out in the first cycle that pin_oe is high.
- R6: The level register returns the pin value after a two-flop synchronizer, for inputs and outputs alike; read data is valid one cycle after the address.
- R7: A 0-to-1 change of the synchronized level sets the status bit only if the rising enable is 1; a 1-to-0 change sets it only if the falling enable is 1.
- R8: Status bits are sticky: writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: When an enabled edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: irq_pin0 equals the status of pin 0 and irq_pin1 equals the status of pin 1; neither reflects any other pin.
- R11: irq_shared is high exactly when any status bit other than pins 0 and 1 is set.
- R12: The address is {bank[4:3], kind[2:0]}. The kind codes are 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable and 6 status. Bank code 3 and kind code 7 read 0 and ignore writes. Pin n sits in bank n/32 at bit n%32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Word address {bank, kind} |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| pin_in | input | 85 | Pad input values |
| pin_out | output | 85 | Output latch values |
| pin_oe | output | 85 | Output enables (direction) |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for all other pins |

## Verification
The two functions that can fall in the same cycle are an edge arriving at a status bit and a write-one-to-clear of that same bit. The bench first sets a status bit with a rising edge and lets the pin fall with the falling enable off. It then raises the pin again. It counts the two synchronizer stages and the edge register, and drives the clearing write so that the write lands on the exact edge where the new event is captured. The bit must read back as set. A following clear with no edge must empty it, which shows the write itself was effective.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    K_LEVEL = 3'd0,
    K_DIR   = 3'd1,
    K_SET   = 3'd2,
    K_CLR   = 3'd3,
    K_RISE  = 3'd4,
    K_FALL  = 3'd5,
    K_STAT  = 3'd6,
    K_NONE  = 3'd7
  } reg_kind_e;

  // Enabled edge events between the previous and current sampled level.
  function automatic logic [WORD_W-1:0] edge_hits(
    input logic [WORD_W-1:0] prev,
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] rise_en,
    input logic [WORD_W-1:0] fall_en);
    return ((cur & ~prev) & rise_en) | ((~cur & prev) & fall_en);
  endfunction

  // Sticky status: clear by write-one, new events win over the clear.
  function automatic logic [WORD_W-1:0] status_next(
    input logic [WORD_W-1:0] status,
    input logic [WORD_W-1:0] hits,
    input logic [WORD_W-1:0] w1c);
    return (status & ~w1c) | hits;
  endfunction

  // Output latch update from set and clear strobes.
  function automatic logic [WORD_W-1:0] latch_next(
    input logic [WORD_W-1:0] latch,
    input logic [WORD_W-1:0] set_m,
    input logic [WORD_W-1:0] clr_m);
    return (latch | set_m) & ~clr_m;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_edge_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [PINS-1:0]   wr_data,
  input  logic [2:0]        rd_kind,
  output logic [WORD_W-1:0] rd_data,
  input  logic [PINS-1:0]   pin_level,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   status,
  output logic [PINS-1:0]   hits
);
  logic [PINS-1:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
  logic [PINS-1:0] set_m, clr_m, w1c_m, kept;
  logic            wr_dir, wr_rise, wr_fall;

  // Named write events
  assign set_m   = (wr_en && wr_kind == K_SET)  ? wr_data : '0;
  assign clr_m   = (wr_en && wr_kind == K_CLR)  ? wr_data : '0;
  assign w1c_m   = (wr_en && wr_kind == K_STAT) ? wr_data : '0;
  assign wr_dir  = wr_en && wr_kind == K_DIR;
  assign wr_rise = wr_en && wr_kind == K_RISE;
  assign wr_fall = wr_en && wr_kind == K_FALL;

  assign hits = PINS'(edge_hits(WORD_W'(prev_q), WORD_W'(pin_level),
                                WORD_W'(rise_q), WORD_W'(fall_q)));
  assign kept = stat_q & ~w1c_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_level;
      out_q  <= PINS'(latch_next(WORD_W'(out_q), WORD_W'(set_m), WORD_W'(clr_m)));
      stat_q <= PINS'(status_next(WORD_W'(stat_q), WORD_W'(hits), WORD_W'(w1c_m)));
      if (wr_dir)  dir_q  <= wr_data;
      if (wr_rise) rise_q <= wr_data;
      if (wr_fall) fall_q <= wr_data;
    end
  end

  always_comb begin
    case (rd_kind)
      K_LEVEL: rd_data = WORD_W'(pin_level);
      K_DIR:   rd_data = WORD_W'(dir_q);
      K_SET,
      K_CLR:   rd_data = WORD_W'(out_q);
      K_RISE:  rd_data = WORD_W'(rise_q);
      K_FALL:  rd_data = WORD_W'(fall_q);
      K_STAT:  rd_data = WORD_W'(stat_q);
      default: rd_data = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign status  = stat_q;

  // Assertions
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(kept)) == $past(kept)));

  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(hits)) == $past(hits)));

  p_set_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != '0) |=> ((out_q & $past(set_m)) == $past(set_m)));

  p_clr_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m != '0) |=> ((out_q & $past(clr_m)) == '0));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m == '0 && clr_m == '0) |=> $stable(out_q));

  p_no_hit_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hits == '0) |=> ((stat_q & ~$past(stat_q)) == '0));
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic [NUM_BANKS*WORD_W-1:0] status_flat,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_shared
);
  localparam int FLAT_W = NUM_BANKS * WORD_W;
  localparam logic [FLAT_W-1:0] SHARED_MASK = ~FLAT_W'(3);

  assign irq_pin0   = status_flat[0];
  assign irq_pin1   = status_flat[1];
  assign irq_shared = |(status_flat & SHARED_MASK);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int LAST_PINS = 21,
  parameter int BANK_AW   = $clog2(NUM_BANKS + 1),
  parameter int NPINS     = (NUM_BANKS - 1) * WORD_W + LAST_PINS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BANK_AW+2:0]     reg_addr,
  input  logic                   reg_wen,
  input  logic [WORD_W-1:0]      reg_wdata,
  output logic [WORD_W-1:0]      reg_rdata,
  input  logic [NPINS-1:0]       pin_in,
  output logic [NPINS-1:0]       pin_out,
  output logic [NPINS-1:0]       pin_oe,
  output logic                   irq_pin0,
  output logic                   irq_pin1,
  output logic                   irq_shared
);
  localparam int ADDR_W = BANK_AW + 3;
  localparam int FLAT_W = NUM_BANKS * WORD_W;

  logic [NPINS-1:0]   pin_sync;
  logic [FLAT_W-1:0]  status_flat;
  logic [FLAT_W-1:0]  hits_flat;
  logic [FLAT_W-1:0]  rdata_flat;
  logic [BANK_AW-1:0] sel_bank;
  logic [2:0]         sel_kind;
  logic [WORD_W-1:0]  rdata_d;

  assign sel_bank = reg_addr[ADDR_W-1:3];
  assign sel_kind = reg_addr[2:0];

  gpio_sync #(.W(NPINS)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int PINS = (b == NUM_BANKS - 1) ? LAST_PINS : WORD_W;
    localparam int LO   = b * WORD_W;
    logic [PINS-1:0]   st, hv;
    logic [WORD_W-1:0] rd;
    logic              we;

    assign we = reg_wen && (sel_bank == BANK_AW'(b));

    gpio_bank #(.PINS(PINS)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(we), .wr_kind(sel_kind), .wr_data(reg_wdata[PINS-1:0]),
      .rd_kind(sel_kind), .rd_data(rd),
      .pin_level(pin_sync[LO +: PINS]),
      .pin_out(pin_out[LO +: PINS]), .pin_oe(pin_oe[LO +: PINS]),
      .status(st), .hits(hv)
    );

    assign status_flat[LO +: WORD_W] = WORD_W'(st);
    assign hits_flat[LO +: WORD_W]   = WORD_W'(hv);
    assign rdata_flat[LO +: WORD_W]  = rd;
  end

  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_bank == BANK_AW'(b)) rdata_d = rdata_flat[b*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rdata_d;
  end

  gpio_irq_merge #(.NUM_BANKS(NUM_BANKS)) merge_i (
    .status_flat(status_flat),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
  );

  // Assertions
  p_rd_bank_none_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_bank) >= NUM_BANKS) |=> (reg_rdata == '0));

  p_rd_kind_none_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_kind == 3'd7) |=> (reg_rdata == '0));

  p_irq0_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pin0 && !hits_flat[0]) |=> !irq_pin0);

  p_irq1_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pin1 && !hits_flat[1]) |=> !irq_pin1);

  p_shared_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_shared && ((hits_flat & ~FLAT_W'(3)) == '0)) |=> !irq_shared);
endmodule

// File: tb/gpio_edge_irq_tb_top.sv
module gpio_edge_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 85;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic        irq_pin0, irq_pin1, irq_shared;
  logic [95:0] ext = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pad model: driven pins read back their own output value.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext[NP-1:0]);

  gpio_edge_irq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin0(irq_pin0),
    .irq_pin1(irq_pin1), .irq_shared(irq_shared)
  );

  localparam logic [2:0] LEVEL = 0, DIR = 1, SETR = 2, CLRR = 3,
                         RISE = 4, FALL = 5, STAT = 6, NONE = 7;

  function automatic logic [4:0] ad(input int bank, input logic [2:0] kind);
    return {2'(bank), kind};
  endfunction

  function automatic logic [31:0] bank_mask(input int bank);
    return (bank == 2) ? 32'h001F_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  bank;
    logic [31:0] start;
    logic [31:0] stop;
    logic [31:0] rise;
    logic [31:0] fall;
    logic [31:0] expect_st;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd1, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_0000},
    '{2'd0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_FFFF},
    '{2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h001F_FFFF},
    '{2'd1, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{2'd0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'h0000_0000, 32'hF0F0_F0F0},
    '{2'd1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", 32'(|pin_oe), 32'h0);
    chk("R1 pin_out", 32'(|pin_out), 32'h0);
    chk("R1 irqs", {29'h0, irq_pin0, irq_pin1, irq_shared}, 32'h0);
    for (int b = 0; b < 3; b++) begin
      rd(ad(b, DIR), d);  chk("R1 dir", d, 32'h0);
      rd(ad(b, STAT), d); chk("R1 status", d, 32'h0);
      rd(ad(b, RISE), d); chk("R1 rise enable", d, 32'h0);
    end

    // Table of edge patterns: R7, R6, R10, R11
    foreach (VECS[i]) begin
      int b;
      logic [31:0] shmask;
      b = int'(VECS[i].bank);
      wr(ad(b, RISE), VECS[i].rise);
      wr(ad(b, FALL), VECS[i].fall);
      ext[b*32 +: 32] = VECS[i].start;
      settle();
      wr(ad(b, STAT), 32'hFFFF_FFFF);
      ext[b*32 +: 32] = VECS[i].stop;
      settle();
      rd(ad(b, STAT), d);  chk("R7 edge status", d, VECS[i].expect_st);
      rd(ad(b, LEVEL), d); chk("R6 level", d, VECS[i].stop & bank_mask(b));
      chk("R10 irq_pin0", 32'(irq_pin0), (b == 0) ? 32'(VECS[i].expect_st[0]) : 32'h0);
      chk("R10 irq_pin1", 32'(irq_pin1), (b == 0) ? 32'(VECS[i].expect_st[1]) : 32'h0);
      shmask = (b == 0) ? 32'hFFFF_FFFC : 32'hFFFF_FFFF;
      chk("R11 irq_shared", 32'(irq_shared), 32'(|(VECS[i].expect_st & shmask)));
      wr(ad(b, RISE), 32'h0);
      wr(ad(b, FALL), 32'h0);
      ext[b*32 +: 32] = 32'h0;
      settle();
      wr(ad(b, STAT), 32'hFFFF_FFFF);
    end

    // R12 unmapped bank and kind
    wr(ad(3, DIR), 32'hFFFF_FFFF);
    wr(ad(0, NONE), 32'hFFFF_FFFF);
    chk("R12 unmapped write oe", 32'(|pin_oe), 32'h0);
    rd(ad(3, DIR), d);  chk("R12 bank 3 read", d, 32'h0);
    rd(ad(0, NONE), d); chk("R12 kind 7 read", d, 32'h0);

    // R2 / R3 direction and bank 2 width
    wr(ad(2, DIR), 32'hFFFF_FFFF);
    rd(ad(2, DIR), d); chk("R3 bank2 dir readback", d, 32'h001F_FFFF);
    chk("R2 bank2 oe", 32'(pin_oe[84:64]), 32'h001F_FFFF);
    chk("R2 other oe", 32'(|pin_oe[63:0]), 32'h0);
    wr(ad(2, DIR), 32'h0);
    chk("R2 oe cleared", 32'(|pin_oe), 32'h0);

    // R4 set/clear, R5 preset, R6 level of outputs
    wr(ad(1, SETR), 32'h0000_00F0);
    rd(ad(1, SETR), d); chk("R4 set", d, 32'h0000_00F0);
    chk("R4 pin_out", 32'(pin_out[39:36]), 32'hF);
    chk("R5 still input", 32'(|pin_oe), 32'h0);
    wr(ad(1, CLRR), 32'h0000_0030);
    rd(ad(1, CLRR), d); chk("R4 clear", d, 32'h0000_00C0);
    wr(ad(1, SETR), 32'h0);
    rd(ad(1, SETR), d); chk("R4 zero set no effect", d, 32'h0000_00C0);
    wr(ad(1, CLRR), 32'h0);
    rd(ad(1, SETR), d); chk("R4 zero clear no effect", d, 32'h0000_00C0);
    wr(ad(1, DIR), 32'h0000_0080);
    chk("R5 first output cycle", {30'h0, pin_oe[39], pin_out[39]}, 32'h3);
    settle();
    rd(ad(1, LEVEL), d); chk("R6 output level", d, 32'h0000_0080);
    wr(ad(1, CLRR), 32'h0000_0080);
    settle();
    rd(ad(1, LEVEL), d); chk("R6 output low level", d, 32'h0);
    wr(ad(1, DIR), 32'h0);
    wr(ad(1, CLRR), 32'hFFFF_FFFF);

    // R10 / R11 / R8 dedicated lines
    wr(ad(0, RISE), 32'h0000_0003);
    ext[0] = 1'b1;
    settle();
    chk("R10 pin0 alone", {29'h0, irq_pin0, irq_pin1, irq_shared}, 32'h4);
    ext[1] = 1'b1;
    settle();
    chk("R11 pins 0 and 1 not shared", {29'h0, irq_pin0, irq_pin1, irq_shared}, 32'h6);
    wr(ad(0, STAT), 32'h0);
    rd(ad(0, STAT), d); chk("R8 zero write keeps", d, 32'h3);
    wr(ad(0, STAT), 32'h1);
    rd(ad(0, STAT), d); chk("R8 clear bit 0 only", d, 32'h2);
    chk("R10 after clear", {29'h0, irq_pin0, irq_pin1, irq_shared}, 32'h2);
    wr(ad(0, STAT), 32'h2);
    wr(ad(0, RISE), 32'h0);
    ext[1:0] = 2'b00;
    settle();

    // R11 highest implemented pin, R7 disabled edge
    wr(ad(2, RISE), 32'h0010_0000);
    ext[85] = 1'b1;
    ext[83] = 1'b1;
    settle();
    chk("R7 disabled edge", 32'(irq_shared), 32'h0);
    ext[84] = 1'b1;
    settle();
    rd(ad(2, STAT), d); chk("R7 bank2 bit 20", d, 32'h0010_0000);
    chk("R11 shared from pin 84", {29'h0, irq_pin0, irq_pin1, irq_shared}, 32'h1);
    wr(ad(2, STAT), 32'hFFFF_FFFF);
    chk("R11 shared clears", 32'(irq_shared), 32'h0);
    wr(ad(2, RISE), 32'h0);
    ext[95:64] = '0;
    settle();

    // R9 edge and clear in the same cycle
    wr(ad(0, RISE), 32'h0000_0004);
    ext[2] = 1'b1;
    settle();
    rd(ad(0, STAT), d); chk("R9 setup", d, 32'h4);
    ext[2] = 1'b0;
    settle();
    @(negedge clk);
    ext[2] = 1'b1;           // sync stage 1, stage 2, then status edge
    @(negedge clk);
    @(negedge clk);
    reg_addr = ad(0, STAT); reg_wdata = 32'h4; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
    rd(ad(0, STAT), d); chk("R9 edge beats clear", d, 32'h4);
    wr(ad(0, STAT), 32'h4);
    rd(ad(0, STAT), d); chk("R8 plain clear", d, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule